// File: doc/BRIEF.md
# Dispatch Completion Signal Sequencer

This block retires compute dispatches through memory. When a dispatch begins, the block saves the present nanosecond time as that dispatch's start time. The saved time is keyed by the address of the dispatch's completion-signal structure. When the dispatch later finishes, the block is handed the same signal address. It then walks a fixed chain of memory transactions on a single request port, and each step waits for the previous response.

The chain has three parts. First comes an optional mailbox notification. The block reads a mailbox pointer from the signal structure. If that pointer is nonzero, it fetches an event word and stores it at the pointer. Second, the block writes a 16-byte record that holds the start time and the end time. Third, it decrements the 64-bit signal value with a read followed by a write. Software treats the signal change as the moment the timestamps are valid. For that reason, the value read is held back until the timestamp write has been acknowledged.

Top module: `sigret_top`

## Requirements
- R1: After reset, `done` and `mem_req_vld` are low and `cmpl_ready` is high.
- R2: A `disp_start` pulse stores the `now_ns` value seen at that clock edge as the start time for `disp_sig_addr`. That value appears in bits 63:0 of the later timestamp write for the same address.
- R3: With a nonzero mailbox pointer, the requests are issued in this order:
  - an 8-byte read at signal+MBX_OFS;
  - an 8-byte read at signal+EVT_OFS;
  - an 8-byte write of the event word (bits 63:0) to the pointer address;
  - the 16-byte timestamp write;
  - an 8-byte read at signal+VAL_OFS;
  - an 8-byte write at signal+VAL_OFS.
- R4: When the mailbox pointer reads as zero, the event read and the mailbox write are both left out. The timestamp write follows the pointer read directly.
- R5: The timestamp write is the only request with `mem_req_wide`=1 (16 bytes). Its address is signal+TS_OFS. Bits 63:0 carry the start time and bits 127:64 carry the end time. The end time is the `now_ns` value at the edge where the request is first raised.
- R6: The final write carries the value read at signal+VAL_OFS minus one, modulo 2^64, so 0 becomes all ones.
- R7: The signal-value read is not issued before the response to the timestamp write has returned.
- R8: Once its timestamp record is written, the start entry for that address is released. A second completion without a new start writes a start time of 0.
- R9: A completion for an address that has no start entry writes a start time of 0.
- R10: At most one request is outstanding. A raised request keeps its fields stable until `mem_req_ready`. No new request appears until the response to the previous one has returned.
- R11: `done` is high for exactly one cycle, in the cycle after the final write's response is seen. `cmpl_ready` is high only when the block is idle. A `cmpl_vld` pulse while busy is ignored and starts no requests.
- R12: The start table holds DEPTH entries. A start for an address already present overwrites its time. A start for a new address when the table is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ns | input | 64 | Free-running nanosecond time |
| disp_start | input | 1 | Dispatch-start strobe |
| disp_sig_addr | input | AW | Signal address of the starting dispatch |
| cmpl_vld | input | 1 | Completion request |
| cmpl_sig_addr | input | AW | Signal address of the finishing dispatch |
| cmpl_ready | output | 1 | Block idle; completion request accepted |
| mem_req_vld | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wide | output | 1 | 1 = 16-byte transfer, 0 = 8-byte |
| mem_req_addr | output | AW | Byte address |
| mem_req_wdata | output | 128 | Write data (8-byte writes use 63:0) |
| mem_rsp_vld | input | 1 | Response strobe for the outstanding request |
| mem_rsp_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The timing of each result is fixed:
- A request is raised two edges after the edge that accepted the completion, or two edges after the edge that saw the previous response.
- `done` rises at the edge that samples the final response.
- The end time equals the time present at the edge where the timestamp request was first raised.

The memory model drives `mem_req_ready`, `mem_rsp_vld` and `now_ns` on falling edges. It logs a request at the falling edge before the accepting rising edge, and it records the time the design saw when the request first rose. The sequence tasks check `done` at the falling edge one cycle after the model drove the last response, and require it low again one cycle later.

// File: rtl/sigret_pkg.sv
package sigret_pkg;
  localparam int WORD_W = 64;
  localparam int REC_W  = 2 * WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MBX_RD = 3'd1,
    ST_EVT_RD = 3'd2,
    ST_MBX_WR = 3'd3,
    ST_TS_WR  = 3'd4,
    ST_VAL_RD = 3'd5,
    ST_VAL_WR = 3'd6
  } step_e;
endpackage

// File: rtl/sigret_start_table.sv
module sigret_start_table
  import sigret_pkg::*;
#(
  parameter int AW    = 48,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_ts,
  input  logic [AW-1:0]     lk_addr,
  input  logic              rel_vld,
  output logic [WORD_W-1:0] lk_ts
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  wr_hit;
  logic [DEPTH-1:0]  lk_hit;
  logic [AW-1:0]     addr_q [DEPTH];
  logic [WORD_W-1:0] ts_q   [DEPTH];

  logic          free_any;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] wr_idx;
  logic          wr_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign wr_hit[g] = vld_q[g] && (addr_q[g] == wr_addr);
    assign lk_hit[g] = vld_q[g] && (addr_q[g] == lk_addr);
  end

  // Lowest free slot and the slot already holding wr_addr.
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    hit_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
      if (wr_hit[i]) hit_idx = IW'(i);
    end
  end

  assign wr_idx = (|wr_hit) ? hit_idx : free_idx;
  assign wr_en  = wr_vld && ((|wr_hit) || free_any);

  always_comb begin
    lk_ts = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_hit[i]) lk_ts = lk_ts | ts_q[i];
    end
  end

  // Valid bits: release first, a new start for the same slot wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (rel_vld) vld_q <= vld_q & ~lk_hit;
      if (wr_en)   vld_q[wr_idx] <= 1'b1;
    end
  end

  // Payload storage without reset so it can map to plain RAM bits.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_idx] <= wr_addr;
      ts_q[wr_idx]   <= wr_ts;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(lk_hit) <= 1);  // R12
  AST_WR_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_hit) <= 1);  // R12
endmodule

// File: rtl/sigret_seq_fsm.sv
module sigret_seq_fsm
  import sigret_pkg::*;
#(
  parameter int AW      = 48,
  parameter int VAL_OFS = 8,
  parameter int MBX_OFS = 16,
  parameter int EVT_OFS = 24,
  parameter int TS_OFS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] now_ns,
  input  logic              cmpl_vld,
  input  logic [AW-1:0]     cmpl_sig_addr,
  output logic              cmpl_ready,
  input  logic [WORD_W-1:0] start_ts,
  output logic [AW-1:0]     lk_addr,
  output logic              rel_vld,
  output logic              mem_req_vld,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic              mem_req_wide,
  output logic [AW-1:0]     mem_req_addr,
  output logic [REC_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_vld,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              done
);
  step_e             step_q;
  logic              wait_q;
  logic [AW-1:0]     sig_q;
  logic [AW-1:0]     mbx_addr_q;
  logic [WORD_W-1:0] evt_q;
  logic [WORD_W-1:0] newval_q;
  logic              rsp_hit;

  assign cmpl_ready = (step_q == ST_IDLE);
  assign lk_addr    = sig_q;
  assign rsp_hit    = wait_q && mem_rsp_vld;
  assign rel_vld    = rsp_hit && (step_q == ST_TS_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q        <= ST_IDLE;
      wait_q        <= 1'b0;
      sig_q         <= '0;
      mbx_addr_q    <= '0;
      evt_q         <= '0;
      newval_q      <= '0;
      done          <= 1'b0;
      mem_req_vld   <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_wide  <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (step_q == ST_IDLE) begin
        if (cmpl_vld) begin
          sig_q  <= cmpl_sig_addr;
          step_q <= ST_MBX_RD;
        end
      end else if (mem_req_vld) begin
        if (mem_req_ready) begin
          mem_req_vld <= 1'b0;
          wait_q      <= 1'b1;
        end
      end else if (wait_q) begin
        if (mem_rsp_vld) begin
          wait_q <= 1'b0;
          unique case (step_q)
            ST_MBX_RD: begin
              mbx_addr_q <= mem_rsp_rdata[AW-1:0];
              step_q     <= (mem_rsp_rdata == '0) ? ST_TS_WR : ST_EVT_RD;
            end
            ST_EVT_RD: begin
              evt_q  <= mem_rsp_rdata;
              step_q <= ST_MBX_WR;
            end
            ST_MBX_WR: step_q <= ST_TS_WR;
            ST_TS_WR:  step_q <= ST_VAL_RD;
            ST_VAL_RD: begin
              newval_q <= mem_rsp_rdata - WORD_W'(1);
              step_q   <= ST_VAL_WR;
            end
            ST_VAL_WR: begin
              done   <= 1'b1;
              step_q <= ST_IDLE;
            end
            default: step_q <= ST_IDLE;
          endcase
        end
      end else begin
        mem_req_vld   <= 1'b1;
        mem_req_we    <= 1'b0;
        mem_req_wide  <= 1'b0;
        mem_req_wdata <= '0;
        unique case (step_q)
          ST_MBX_RD: mem_req_addr <= sig_q + AW'(MBX_OFS);
          ST_EVT_RD: mem_req_addr <= sig_q + AW'(EVT_OFS);
          ST_MBX_WR: begin
            mem_req_addr  <= mbx_addr_q;
            mem_req_we    <= 1'b1;
            mem_req_wdata <= {{WORD_W{1'b0}}, evt_q};
          end
          ST_TS_WR: begin
            mem_req_addr  <= sig_q + AW'(TS_OFS);
            mem_req_we    <= 1'b1;
            mem_req_wide  <= 1'b1;
            mem_req_wdata <= {now_ns, start_ts};
          end
          ST_VAL_RD: mem_req_addr <= sig_q + AW'(VAL_OFS);
          ST_VAL_WR: begin
            mem_req_addr  <= sig_q + AW'(VAL_OFS);
            mem_req_we    <= 1'b1;
            mem_req_wdata <= {{WORD_W{1'b0}}, newval_q};
          end
          default: mem_req_vld <= 1'b0;
        endcase
      end
    end
  end

  // Tracks that the timestamp response came back during this completion.
  logic ts_seen_q;
  always_ff @(posedge clk) begin
    if (rst || step_q == ST_IDLE) ts_seen_q <= 1'b0;
    else if (rel_vld)             ts_seen_q <= 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_vld && !mem_req_ready |=> mem_req_vld && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_we));  // R10
  AST_REQ_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_vld) |-> $past(mem_rsp_vld, 2) || $past(cmpl_vld && cmpl_ready, 2));  // R10
  AST_VAL_AFTER_TS: assert property (@(posedge clk) disable iff (rst)
    mem_req_vld && !mem_req_we && mem_req_addr == sig_q + AW'(VAL_OFS) |-> ts_seen_q);  // R7
  AST_WIDE_IS_TS: assert property (@(posedge clk) disable iff (rst)
    mem_req_vld && mem_req_wide |-> mem_req_we && mem_req_addr == sig_q + AW'(TS_OFS));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmpl_ready |-> !mem_req_vld);  // R11
endmodule

// File: rtl/sigret_top.sv
module sigret_top
  import sigret_pkg::*;
#(
  parameter int AW      = 48,
  parameter int DEPTH   = 8,
  parameter int VAL_OFS = 8,
  parameter int MBX_OFS = 16,
  parameter int EVT_OFS = 24,
  parameter int TS_OFS  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [63:0]   now_ns,
  input  logic          disp_start,
  input  logic [AW-1:0] disp_sig_addr,
  input  logic          cmpl_vld,
  input  logic [AW-1:0] cmpl_sig_addr,
  output logic          cmpl_ready,
  output logic          mem_req_vld,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic          mem_req_wide,
  output logic [AW-1:0] mem_req_addr,
  output logic [127:0]  mem_req_wdata,
  input  logic          mem_rsp_vld,
  input  logic [63:0]   mem_rsp_rdata,
  output logic          done
);
  logic [WORD_W-1:0] start_ts;
  logic [AW-1:0]     lk_addr;
  logic              rel_vld;

  sigret_start_table #(.AW(AW), .DEPTH(DEPTH)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (disp_start),
    .wr_addr (disp_sig_addr),
    .wr_ts   (now_ns),
    .lk_addr (lk_addr),
    .rel_vld (rel_vld),
    .lk_ts   (start_ts)
  );

  sigret_seq_fsm #(
    .AW(AW), .VAL_OFS(VAL_OFS), .MBX_OFS(MBX_OFS),
    .EVT_OFS(EVT_OFS), .TS_OFS(TS_OFS)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .now_ns        (now_ns),
    .cmpl_vld      (cmpl_vld),
    .cmpl_sig_addr (cmpl_sig_addr),
    .cmpl_ready    (cmpl_ready),
    .start_ts      (start_ts),
    .lk_addr       (lk_addr),
    .rel_vld       (rel_vld),
    .mem_req_vld   (mem_req_vld),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_wide  (mem_req_wide),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_vld   (mem_rsp_vld),
    .mem_rsp_rdata (mem_rsp_rdata),
    .done          (done)
  );
endmodule

// File: tb/sim_sigret_top.sv
module sim_sigret_top;
  localparam int PERIOD  = 10;
  localparam int AW      = 48;
  localparam int DEPTH   = 8;
  localparam int VAL_OFS = 8;
  localparam int MBX_OFS = 16;
  localparam int EVT_OFS = 24;
  localparam int TS_OFS  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   now_ns = 64'h1_0000_0000;
  logic          disp_start = 1'b0;
  logic [AW-1:0] disp_sig_addr = '0;
  logic          cmpl_vld = 1'b0;
  logic [AW-1:0] cmpl_sig_addr = '0;
  logic          cmpl_ready;
  logic          mem_req_vld;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic          mem_req_wide;
  logic [AW-1:0] mem_req_addr;
  logic [127:0]  mem_req_wdata;
  logic          mem_rsp_vld = 1'b0;
  logic [63:0]   mem_rsp_rdata = '0;
  logic          done;

  always #(PERIOD/2) clk = ~clk;

  sigret_top #(.AW(AW), .DEPTH(DEPTH), .VAL_OFS(VAL_OFS), .MBX_OFS(MBX_OFS),
               .EVT_OFS(EVT_OFS), .TS_OFS(TS_OFS)) u0 (
    .clk(clk), .rst(rst), .now_ns(now_ns), .disp_start(disp_start),
    .disp_sig_addr(disp_sig_addr), .cmpl_vld(cmpl_vld), .cmpl_sig_addr(cmpl_sig_addr),
    .cmpl_ready(cmpl_ready), .mem_req_vld(mem_req_vld), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_wide(mem_req_wide), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_vld(mem_rsp_vld),
    .mem_rsp_rdata(mem_rsp_rdata), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model state
  logic [AW-1:0] cur_sig = '0;
  logic [63:0]   cur_mbx = '0, cur_evt = '0, cur_val = '0;
  int            cyc = 0, last_rsp_cyc = 0;
  bit            rsp_pend = 0, rsp_is_ts = 0, ts_rsp_back = 0;
  int            rsp_cnt = 0;
  logic [63:0]   rsp_data = '0;
  bit            prev_vld = 0, prev_acc = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [127:0]  prev_wdata = '0;
  logic [63:0]   first_now = '0;

  int            n_log = 0;
  bit            log_we   [16];
  bit            log_wide [16];
  logic [AW-1:0] log_addr [16];
  logic [127:0]  log_data [16];
  logic [63:0]   log_now  [16];

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rsp_vld = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rsp_vld   = 1'b1;
        mem_rsp_rdata = rsp_data;
        rsp_pend      = 0;
        last_rsp_cyc  = cyc;
        if (rsp_is_ts) ts_rsp_back = 1;
      end else begin
        rsp_cnt = rsp_cnt - 1;
      end
    end
    if (!rst) begin
      if (prev_vld && !prev_acc)
        chk(mem_req_vld && mem_req_addr == prev_addr && mem_req_wdata == prev_wdata,
            "R10 request held until ready", mem_req_wdata, prev_wdata);
      if (mem_req_vld && rsp_pend)
        chk(0, "R10 request while outstanding", 1, 0);
      if (mem_req_vld && !prev_vld) first_now = now_ns;
      begin
        bit r;
        r = ($urandom % 4) != 0;
        if (mem_req_vld && r) begin
          if (n_log < 16) begin
            log_we[n_log]   = mem_req_we;
            log_wide[n_log] = mem_req_wide;
            log_addr[n_log] = mem_req_addr;
            log_data[n_log] = mem_req_wdata;
            log_now[n_log]  = first_now;
          end
          n_log++;
          if (!mem_req_we && mem_req_addr == cur_sig + AW'(VAL_OFS))
            chk(ts_rsp_back, "R7 value read after timestamp response", 0, 1);
          rsp_pend  = 1;
          rsp_cnt   = $urandom % 3;
          rsp_is_ts = mem_req_wide;
          if (mem_req_we) rsp_data = '0;
          else if (mem_req_addr == cur_sig + AW'(MBX_OFS)) rsp_data = cur_mbx;
          else if (mem_req_addr == cur_sig + AW'(EVT_OFS)) rsp_data = cur_evt;
          else if (mem_req_addr == cur_sig + AW'(VAL_OFS)) rsp_data = cur_val;
          else rsp_data = '0;
        end
        prev_acc = mem_req_vld && r;
        mem_req_ready = r;
      end
      prev_vld   = mem_req_vld;
      prev_addr  = mem_req_addr;
      prev_wdata = mem_req_wdata;
    end
    now_ns = now_ns + 64'd7;
  end

  // Reference start table, following R12 and R8
  bit            m_vld [DEPTH];
  logic [AW-1:0] m_addr[DEPTH];
  logic [63:0]   m_ts  [DEPTH];

  task automatic model_start(input logic [AW-1:0] a, input logic [63:0] t);
    int hit = -1, fr = -1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m_vld[i] && m_addr[i] == a) hit = i;
      if (!m_vld[i]) fr = i;
    end
    if (hit >= 0) m_ts[hit] = t;
    else if (fr >= 0) begin m_vld[fr] = 1; m_addr[fr] = a; m_ts[fr] = t; end
  endtask

  function automatic logic [63:0] model_take(input logic [AW-1:0] a);
    logic [63:0] t = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_addr[i] == a) begin t = m_ts[i]; m_vld[i] = 0; end
    return t;
  endfunction

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); #1;
    disp_start = 1; disp_sig_addr = a;
    model_start(a, now_ns);
    @(negedge clk); #1;
    disp_start = 0;
  endtask

  task automatic run_cmpl(input logic [AW-1:0] sig, input logic [63:0] mbx, input logic [63:0] evt,
                          input logic [63:0] val, input logic [63:0] exp_start, input bit poke);
    int t, ne, k;
    bit            e_we[6], e_wide[6];
    logic [AW-1:0] e_addr[6];
    logic [63:0]   e_dat[6];
    @(negedge clk); #1;
    cur_sig = sig; cur_mbx = mbx; cur_evt = evt; cur_val = val;
    n_log = 0; ts_rsp_back = 0;
    chk(cmpl_ready, "R11 ready while idle", cmpl_ready, 1);
    cmpl_vld = 1; cmpl_sig_addr = sig;
    @(negedge clk); #1;
    cmpl_vld = 0;
    if (poke) begin
      repeat (2) @(negedge clk); #1;
      chk(!cmpl_ready, "R11 not ready while busy", cmpl_ready, 0);
      cmpl_vld = 1; cmpl_sig_addr = sig ^ 48'h4000;
      @(negedge clk); #1;
      cmpl_vld = 0;
    end
    t = 0;
    while (!done && t < 500) begin @(negedge clk); #1; t++; end
    chk(done, "R11 done asserted", done, 1);
    chk(cyc == last_rsp_cyc + 1, "R11 done one cycle after final response", cyc, last_rsp_cyc + 1);
    @(negedge clk); #1;
    chk(!done, "R11 done single cycle", done, 0);
    repeat (12) @(negedge clk); #1;
    chk(!mem_req_vld && cmpl_ready, "R11 quiet after done", mem_req_vld, 0);
    // expected sequence (R3 / R4)
    ne = 0;
    e_we[ne] = 0; e_wide[ne] = 0; e_addr[ne] = sig + AW'(MBX_OFS); e_dat[ne] = 0; ne++;
    if (mbx != 0) begin
      e_we[ne] = 0; e_wide[ne] = 0; e_addr[ne] = sig + AW'(EVT_OFS); e_dat[ne] = 0; ne++;
      e_we[ne] = 1; e_wide[ne] = 0; e_addr[ne] = mbx[AW-1:0];       e_dat[ne] = evt; ne++;
    end
    k = ne;
    e_we[ne] = 1; e_wide[ne] = 1; e_addr[ne] = sig + AW'(TS_OFS);  e_dat[ne] = exp_start; ne++;
    e_we[ne] = 0; e_wide[ne] = 0; e_addr[ne] = sig + AW'(VAL_OFS); e_dat[ne] = 0; ne++;
    e_we[ne] = 1; e_wide[ne] = 0; e_addr[ne] = sig + AW'(VAL_OFS); e_dat[ne] = val - 64'd1; ne++;
    chk(n_log == ne, mbx != 0 ? "R3 request count" : "R4 request count", n_log, ne);
    if (n_log == ne) begin
      for (int i = 0; i < ne; i++) begin
        chk(log_we[i] == e_we[i] && log_addr[i] == e_addr[i],
            mbx != 0 ? "R3 request kind/address" : "R4 request kind/address",
            {log_we[i], log_addr[i]}, {e_we[i], e_addr[i]});
        chk(log_wide[i] == e_wide[i], "R5 width flag", log_wide[i], e_wide[i]);
      end
      chk(log_data[k][63:0] == exp_start, "R2 R8 R9 start time", log_data[k][63:0], exp_start);
      chk(log_data[k][127:64] == log_now[k], "R5 end time", log_data[k][127:64], log_now[k]);
      chk(log_data[ne-1][63:0] == val - 64'd1, "R6 decremented value", log_data[ne-1][63:0], val - 64'd1);
      if (mbx != 0)
        chk(log_data[1 + 1][63:0] == evt, "R3 mailbox data", log_data[2][63:0], evt);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [AW-1:0] a;
    logic [63:0]   t0, mb;
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !mem_req_vld && cmpl_ready, "R1 reset state", {done, mem_req_vld, cmpl_ready}, 3'b001);
    rst = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!done && !mem_req_vld && cmpl_ready, "R1 after reset release", {done, mem_req_vld, cmpl_ready}, 3'b001);

    // R3 R2 R5 R6 R7: full chain with a mailbox
    a = 48'h1000;
    do_start(a);
    run_cmpl(a, 64'h0000_7F00_0000_0040, 64'hDEAD_BEEF_0000_0011, 64'd5, model_take(a), 0);
    // R8: start entry released, second completion yields zero start
    run_cmpl(a, 64'h0, 64'h0, 64'd9, model_take(a), 0);
    // R4: mailbox pointer zero
    a = 48'h2000;
    do_start(a);
    run_cmpl(a, 64'h0, 64'h1234, 64'd100, model_take(a), 0);
    // R9: unknown address, R6: value 0 wraps
    run_cmpl(48'h3000, 64'h0, 64'h0, 64'd0, model_take(48'h3000), 0);
    // R11: completion while busy ignored
    a = 48'h5000;
    do_start(a);
    run_cmpl(a, 64'h0000_0000_0ABC_0000, 64'h77, 64'd3, model_take(a), 1);

    // R12: capacity, overwrite and drop
    for (int i = 0; i < DEPTH; i++) do_start(48'h10000 + AW'(i * 64));
    repeat (5) @(negedge clk);
    do_start(48'h10000 + 48'd128);           // overwrite existing
    do_start(48'h90000);                     // table full: dropped
    t0 = model_take(48'h90000);
    chk(t0 == 0, "R12 model dropped entry", t0, 0);
    run_cmpl(48'h90000, 64'h0, 64'h0, 64'd2, t0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      a = 48'h10000 + AW'(i * 64);
      run_cmpl(a, 64'h0, 64'h0, 64'd40 + 64'(i), model_take(a), 0);
    end

    // Random mix
    for (int it = 0; it < 25; it++) begin
      int ns;
      ns = $urandom % 3;
      for (int s = 0; s < ns; s++) do_start(48'h8000 + AW'(($urandom % 10) * 256));
      a  = 48'h8000 + AW'(($urandom % 10) * 256);
      mb = ($urandom % 2) ? 64'h0 : {32'h0, 16'h0020, $urandom} & 64'h0000_FFFF_FFFF_FFF8;
      run_cmpl(a, mb, {$urandom, $urandom}, {$urandom, $urandom}, model_take(a), ($urandom % 4) == 0);
    end
    summary();
  end
endmodule